// File: doc/BRIEF.md
# Two-Bank Flash Program/Erase Sequencer

This block puts a 16-bit register port in front of a small two-bank nonvolatile array, modelled in flip-flops, and runs the write-type operations on it. Software picks an operation in an operation-select register: word program, double-word program, sector erase or protection write. It then loads address, data and sector-select registers and sets a start bit in the status/command register. While the operation runs, the register file is locked and only the bank being modified is marked busy. The other bank can still be read through a separate 32-bit array read port. Programming can only clear bits. Erase returns whole sectors to all-ones. Two protection words sit in a small reserved address window.

The sequencer has four states. In `S_IDLE` it waits for a start request. Start with a valid command is the *launch* transition to `S_RUN`. In `S_RUN` a cycle counter, loaded with the program or erase duration, counts down. A suspend request is the *pause* transition to `S_SUSP`, where the busy flags drop but the lock is held. A resume request is the *resume* transition back to `S_RUN`, keeping the remaining count. When the count reaches zero, the *expire* transition leads to `S_COMMIT`. That state applies the update to the array in one cycle, then takes the *finish* transition back to `S_IDLE`, clearing the operation select. An invalid start is the *reject* event: the block stays in `S_IDLE` and sets the sequence-error flag.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, the status register (index 0) reads 0, the operation-select (index 1) and error (index 8) registers read 0, every array word reads 32'hFFFF_FFFF with `rd_invalid` low, and both protection words read all-ones.
- R2: A start (status bit 0 written as 1 in `S_IDLE`) with exactly one valid operation sets lock (status bit 1) and only the target bank's busy flag (bit 2 for bank 0, bit 3 for bank 1) in the next cycle. Word addresses 0..7 are bank 0, 8..15 are bank 1, and protection writes target bank 0.
- R3: While a bank is busy, array reads of that bank give `rd_invalid`=1 and `rd_data`=0, while reads of the other bank return stored data. Addresses outside both the array and the protection window always read as invalid.
- R4: While locked, registers other than the status register read 16'hDEAD, and writes to them or a further start have no effect. The status register stays readable.
- R5: Word program (operation-select bit 0) stores old AND {data-low-high (index 5), data-low-low (index 4)} at the address in index 2, and busy lasts exactly PROG_CYC+1 cycles.
- R6: Double-word program (bit 1) needs an even address. It ANDs the first data pair (indexes 4/5) into the even word and the second pair (indexes 6/7) into the odd word, and busy lasts PROG_CYC+1 cycles.
- R7: Sector erase (bit 2) sets every word of each sector whose bit is set in the sector-select register (index 3; bit k covers words k*WPS..k*WPS+WPS-1) to all-ones, and busy lasts ERASE_CYC+1 cycles. An empty mask, or a mask that touches both banks, is rejected.
- R8: A protection write (bit 3) whose address lies in [PROT_BASE, PROT_BASE+PROT_WORDS) ANDs the first data pair into that protection word, which reads back through the array port at the same address. An address outside the window sets error bit 0 and starts nothing.
- R9: A start with zero or several operation-select bits set, a word program outside the array, or a double-word program at an odd address sets error bit 0 and does not lock.
- R10: At the end of an operation, the operation-select register reads 0 and the lock and busy flags are clear.
- R11: Writing status bit 4 during `S_RUN` suspends the operation. Busy clears, lock stays set, and status bit 4 reads 1; the target bank is readable with its old contents. Writing status bit 5 resumes the operation, which sets busy again and completes the remaining cycles.
- R12: Error bit 0 is cleared by writing 1 to it only while unlocked; a clear attempted while locked leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rd_addr | input | 16 | Array read word address |
| rd_data | output | 32 | Array read data |
| rd_invalid | output | 1 | Read hit a busy bank or an unmapped address |

## Verification
The hardest state to reach from the ports is a suspended erase. It needs a start and a suspend write that both land within the erase window. The target bank must also be read while the lock is still held, and the resume must continue from the frozen count. The bench fills the array with a known pattern first, so an erase that ran too early or too far is visible. It issues the suspend two cycles after launch, waits well past the erase length, and checks that the lock persists, the old data is still present and the sector ends at all-ones only after resume. Sweeps over every address, every single and paired sector mask and all sixteen operation-select codes cover the rest.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    typedef enum logic [1:0] {OP_WPROG, OP_DPROG, OP_ERASE, OP_PROT} op_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_SUSP, S_COMMIT} state_e;

    localparam logic [3:0] RA_STAT  = 4'd0;
    localparam logic [3:0] RA_OPSEL = 4'd1;
    localparam logic [3:0] RA_ADDR  = 4'd2;
    localparam logic [3:0] RA_SECT  = 4'd3;
    localparam logic [3:0] RA_D0L   = 4'd4;
    localparam logic [3:0] RA_D0H   = 4'd5;
    localparam logic [3:0] RA_D1L   = 4'd6;
    localparam logic [3:0] RA_D1H   = 4'd7;
    localparam logic [3:0] RA_ERR   = 4'd8;
endpackage

// File: rtl/fpe_regs.sv
module fpe_regs
    import fpe_pkg::*;
#(
    parameter int          NSECT   = 4,
    parameter logic [15:0] INVALID = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              lock,
    input  logic [1:0]        busy,
    input  logic              suspended,
    input  logic              seq_err,
    input  logic              commit,
    output logic              go,
    output logic              susp_req,
    output logic              res_req,
    output logic [3:0]        opsel,
    output logic [15:0]       addr,
    output logic [NSECT-1:0]  sect,
    output logic [31:0]       d0,
    output logic [31:0]       d1
);
    logic [15:0] d0l_q, d0h_q, d1l_q, d1h_q;
    logic        err_q;
    logic        wr_open;
    logic        stat_wr;

    assign wr_open  = reg_wr && !lock;
    assign stat_wr  = reg_wr && (reg_sel == RA_STAT);
    assign go       = stat_wr && reg_wdata[0] && !lock;
    assign susp_req = stat_wr && reg_wdata[4];
    assign res_req  = stat_wr && reg_wdata[5];
    assign d0       = {d0h_q, d0l_q};
    assign d1       = {d1h_q, d1l_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opsel <= '0;
            addr  <= '0;
            sect  <= '0;
            d0l_q <= '0;
            d0h_q <= '0;
            d1l_q <= '0;
            d1h_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (commit) begin
                opsel <= '0;
            end else if (wr_open && reg_sel == RA_OPSEL) begin
                opsel <= reg_wdata[3:0];
            end
            if (wr_open) begin
                case (reg_sel)
                    RA_ADDR: addr  <= reg_wdata;
                    RA_SECT: sect  <= reg_wdata[NSECT-1:0];
                    RA_D0L:  d0l_q <= reg_wdata;
                    RA_D0H:  d0h_q <= reg_wdata;
                    RA_D1L:  d1l_q <= reg_wdata;
                    RA_D1H:  d1h_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (seq_err) begin
                err_q <= 1'b1;
            end else if (wr_open && reg_sel == RA_ERR && reg_wdata[0]) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == RA_STAT) begin
            reg_rdata = {11'b0, suspended, busy[1], busy[0], lock, 1'b0};
        end else if (lock) begin
            reg_rdata = INVALID;
        end else begin
            case (reg_sel)
                RA_OPSEL: reg_rdata = {12'b0, opsel};
                RA_ADDR:  reg_rdata = addr;
                RA_SECT:  reg_rdata = 16'(sect);
                RA_D0L:   reg_rdata = d0l_q;
                RA_D0H:   reg_rdata = d0h_q;
                RA_D1L:   reg_rdata = d1l_q;
                RA_D1H:   reg_rdata = d1h_q;
                RA_ERR:   reg_rdata = {15'b0, err_q};
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R10: operation select self-clears after the commit cycle
    p_opsel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (opsel == '0));

    // R4: locked address register keeps its value under a write
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && reg_wr && reg_sel == RA_ADDR) |=> $stable(addr));

    // R12: a locked clear attempt leaves the error flag set
    p_err_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && err_q) |=> err_q);
endmodule

// File: rtl/fpe_seq.sv
module fpe_seq
    import fpe_pkg::*;
#(
    parameter int          SPB        = 2,
    parameter int          WPS        = 4,
    parameter int          PROG_CYC   = 4,
    parameter int          ERASE_CYC  = 12,
    parameter logic [15:0] PROT_BASE  = 16'h0100,
    parameter int          PROT_WORDS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               go,
    input  logic                               susp_req,
    input  logic                               res_req,
    input  logic [3:0]                         opsel,
    input  logic [15:0]                        addr,
    input  logic [2*SPB-1:0]                   sect,
    output logic [1:0]                         busy,
    output logic                               lock,
    output logic                               suspended,
    output logic                               commit,
    output logic                               seq_err,
    output op_e                                cur_op,
    output logic [$clog2(2*SPB*WPS)-1:0]       widx,
    output logic [$clog2(PROT_WORDS)-1:0]      pidx
);
    localparam int          NSECT = 2 * SPB;
    localparam int          TOTAL = NSECT * WPS;
    localparam int          AWI   = $clog2(TOTAL);
    localparam int          PW    = $clog2(PROT_WORDS);
    localparam int          MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int          CW    = $clog2(MAXC + 1);
    localparam logic [15:0] TOT16 = 16'(TOTAL);
    localparam logic [15:0] PEND  = PROT_BASE + 16'(PROT_WORDS);

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          bank_q;
    op_e           op_d;
    logic          bank_d;
    logic          cmd_ok;
    logic          start_ok;
    logic          in_arr, in_prot, sect_b0, sect_b1;

    assign in_arr  = addr < TOT16;
    assign in_prot = (addr >= PROT_BASE) && (addr < PEND);
    assign sect_b0 = |sect[SPB-1:0];
    assign sect_b1 = |sect[NSECT-1:SPB];
    assign widx    = addr[AWI-1:0];
    assign pidx    = addr[PW-1:0];

    // command decode and legality
    always_comb begin
        cmd_ok = 1'b0;
        op_d   = OP_WPROG;
        bank_d = 1'b0;
        case (opsel)
            4'b0001: begin op_d = OP_WPROG; cmd_ok = in_arr;               bank_d = addr[AWI-1]; end
            4'b0010: begin op_d = OP_DPROG; cmd_ok = in_arr && !addr[0];   bank_d = addr[AWI-1]; end
            4'b0100: begin op_d = OP_ERASE; cmd_ok = sect_b0 ^ sect_b1;    bank_d = sect_b1;     end
            4'b1000: begin op_d = OP_PROT;  cmd_ok = in_prot;              bank_d = 1'b0;        end
            default: ;
        endcase
    end

    assign start_ok = go && (state_q == S_IDLE) && cmd_ok;
    assign seq_err  = go && (state_q == S_IDLE) && !cmd_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cur_op  <= OP_WPROG;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                cur_op <= op_d;
                bank_q <= bank_d;
                cnt_q  <= (op_d == OP_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
            end else if (state_q == S_RUN && !susp_req && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_ok) state_d = S_RUN;
            S_RUN:    if (susp_req) state_d = S_SUSP;
                      else if (cnt_q == '0) state_d = S_COMMIT;
            S_SUSP:   if (res_req) state_d = S_RUN;
            S_COMMIT: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 2'b00;
        lock      = 1'b0;
        suspended = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_RUN:    begin lock = 1'b1; busy[bank_q] = 1'b1; end
            S_SUSP:   begin lock = 1'b1; suspended = 1'b1; end
            S_COMMIT: begin lock = 1'b1; busy[bank_q] = 1'b1; commit = 1'b1; end
        endcase
    end

    p_busy_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != 2'b00) |-> lock);
    p_busy_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));
    p_start_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (lock && busy != 2'b00));
    p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !lock);
    p_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (lock && busy == 2'b00));
    p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!lock && busy == 2'b00));
endmodule

// File: rtl/fpe_array.sv
module fpe_array
    import fpe_pkg::*;
#(
    parameter int          SPB        = 2,
    parameter int          WPS        = 4,
    parameter logic [15:0] PROT_BASE  = 16'h0100,
    parameter int          PROT_WORDS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  op_e                                op,
    input  logic [$clog2(2*SPB*WPS)-1:0]       widx,
    input  logic [$clog2(PROT_WORDS)-1:0]      pidx,
    input  logic [2*SPB-1:0]                   sect,
    input  logic [31:0]                        d0,
    input  logic [31:0]                        d1,
    input  logic [1:0]                         busy,
    input  logic [15:0]                        rd_addr,
    output logic [31:0]                        rd_data,
    output logic                               rd_invalid
);
    localparam int          NSECT = 2 * SPB;
    localparam int          TOTAL = NSECT * WPS;
    localparam int          AWI   = $clog2(TOTAL);
    localparam int          PW    = $clog2(PROT_WORDS);
    localparam logic [15:0] TOT16 = 16'(TOTAL);
    localparam logic [15:0] PEND  = PROT_BASE + 16'(PROT_WORDS);

    logic [31:0] mem  [TOTAL];
    logic [31:0] prot [PROT_WORDS];
    logic [AWI-1:0] odd_idx;

    assign odd_idx = {widx[AWI-1:1], 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
            for (int j = 0; j < PROT_WORDS; j++) prot[j] <= '1;
        end else if (commit) begin
            unique case (op)
                OP_WPROG: mem[widx] <= mem[widx] & d0;
                OP_DPROG: begin
                    mem[widx]    <= mem[widx] & d0;
                    mem[odd_idx] <= mem[odd_idx] & d1;
                end
                OP_ERASE: begin
                    for (int i = 0; i < TOTAL; i++) begin
                        if (sect[i / WPS]) mem[i] <= '1;
                    end
                end
                OP_PROT:  prot[pidx] <= prot[pidx] & d0;
            endcase
        end
    end

    always_comb begin
        rd_data    = '0;
        rd_invalid = 1'b1;
        if (rd_addr < TOT16) begin
            if (!busy[rd_addr[AWI-1]]) begin
                rd_data    = mem[rd_addr[AWI-1:0]];
                rd_invalid = 1'b0;
            end
        end else if (rd_addr >= PROT_BASE && rd_addr < PEND) begin
            if (!busy[0]) begin
                rd_data    = prot[rd_addr[PW-1:0]];
                rd_invalid = 1'b0;
            end
        end
    end

    // R5: a word program never raises a bit
    p_prog_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_WPROG) |=> ((mem[$past(widx)] & ~$past(mem[widx])) == 32'h0));

    // R3: a busy bank never returns valid data
    p_busy_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < TOT16 && busy[rd_addr[AWI-1]]) |-> (rd_invalid && rd_data == 32'h0));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import fpe_pkg::*;
#(
    parameter int          SPB        = 2,
    parameter int          WPS        = 4,
    parameter int          PROG_CYC   = 4,
    parameter int          ERASE_CYC  = 12,
    parameter logic [15:0] PROT_BASE  = 16'h0100,
    parameter int          PROT_WORDS = 2,
    parameter logic [15:0] INVALID    = 16'hDEAD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [15:0] rd_addr,
    output logic [31:0] rd_data,
    output logic        rd_invalid
);
    localparam int NSECT = 2 * SPB;
    localparam int AWI   = $clog2(NSECT * WPS);
    localparam int PW    = $clog2(PROT_WORDS);

    logic             go, susp_req, res_req;
    logic [3:0]       opsel;
    logic [15:0]      addr;
    logic [NSECT-1:0] sect;
    logic [31:0]      d0, d1;
    logic [1:0]       busy;
    logic             lock, suspended, commit, seq_err;
    op_e              cur_op;
    logic [AWI-1:0]   widx;
    logic [PW-1:0]    pidx;

    fpe_regs #(.NSECT(NSECT), .INVALID(INVALID)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock(lock), .busy(busy),
        .suspended(suspended), .seq_err(seq_err), .commit(commit), .go(go),
        .susp_req(susp_req), .res_req(res_req), .opsel(opsel), .addr(addr),
        .sect(sect), .d0(d0), .d1(d1)
    );

    fpe_seq #(.SPB(SPB), .WPS(WPS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
              .PROT_BASE(PROT_BASE), .PROT_WORDS(PROT_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .susp_req(susp_req), .res_req(res_req),
        .opsel(opsel), .addr(addr), .sect(sect), .busy(busy), .lock(lock),
        .suspended(suspended), .commit(commit), .seq_err(seq_err), .cur_op(cur_op),
        .widx(widx), .pidx(pidx)
    );

    fpe_array #(.SPB(SPB), .WPS(WPS), .PROT_BASE(PROT_BASE), .PROT_WORDS(PROT_WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(cur_op), .widx(widx),
        .pidx(pidx), .sect(sect), .d0(d0), .d1(d1), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_invalid(rd_invalid)
    );
endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          PROG  = 4;
    localparam int          ERASE = 12;
    localparam int          NW    = 16;
    localparam logic [15:0] PBASE = 16'h0100;
    localparam logic [15:0] INV   = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_invalid;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] em [NW];
    logic [31:0] ep [2];

    flash_pe_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERASE)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_invalid(rd_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [15:0] d);
        reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [15:0] d);
        reg_sel = a; #1; d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic rarr(input logic [15:0] a, output logic [31:0] d, output logic inv);
        rd_addr = a; #1; d = rd_data; inv = rd_invalid;
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] a, input logic [31:0] x, input logic [31:0] y);
        wreg(4'd2, a);
        wreg(4'd4, x[15:0]); wreg(4'd5, x[31:16]);
        wreg(4'd6, y[15:0]); wreg(4'd7, y[31:16]);
    endtask

    task automatic run_op(input logic [3:0] op, output int cyc);
        logic [15:0] s;
        wreg(4'd1, {12'b0, op});
        wreg(4'd0, 16'h0001);
        cyc = 0;
        for (int g = 0; g < 1000; g++) begin
            rreg(4'd0, s);
            if (!s[1]) break;
            cyc++;
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] d; logic inv;
        for (int i = 0; i < NW; i++) begin
            rarr(16'(i), d, inv);
            chk(req, {inv, d[30:0]}, {1'b0, em[i][30:0]});
            chk(req, {31'b0, d[31]}, {31'b0, em[i][31]});
        end
    endtask

    task automatic prog_all(input logic [31:0] seed);
        int c;
        for (int i = 0; i < NW; i++) begin
            logic [31:0] d;
            d = seed ^ (32'(i) * 32'h0103_0507);
            load(16'(i), d, 32'h0);
            run_op(4'b0001, c);
            em[i] = em[i] & d;
        end
    endtask

    initial begin
        logic [15:0] s;
        logic [31:0] d;
        logic        inv;
        int          c;

        for (int i = 0; i < NW; i++) em[i] = '1;
        ep[0] = '1; ep[1] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rreg(4'd0, s); chk("R1 stat", 32'(s), 32'h0);
        rreg(4'd1, s); chk("R1 opsel", 32'(s), 32'h0);
        rreg(4'd8, s); chk("R1 err", 32'(s), 32'h0);
        check_all("R1 array");
        for (int k = 0; k < 2; k++) begin
            rarr(PBASE + 16'(k), d, inv);
            chk("R1 prot", d, 32'hFFFF_FFFF);
            chk("R1 prot valid", 32'(inv), 32'h0);
        end

        // R5: word program sweep, two passes to exercise AND
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NW; i++) begin
                d = (p == 0) ? 32'hFFFF_FFFF - (32'h0101 << i)
                             : 32'h3C3C_0FF0 ^ (32'(i) * 32'h0011_0101);
                load(16'(i), d, 32'h0);
                run_op(4'b0001, c);
                chk("R5 busy cycles", 32'(c), 32'(PROG + 1));
                em[i] = em[i] & d;
                rarr(16'(i), d, inv);
                chk("R5 readback", d, em[i]);
            end
        end

        // R7: erase every single sector, pairs in one bank, and illegal masks
        for (int m = 0; m < 16; m++) begin
            logic [3:0] mask;
            logic legal;
            mask = 4'(m);
            legal = (mask != 0) && ((mask[1:0] == 0) != (mask[3:2] == 0));
            if (!(mask == 1 || mask == 2 || mask == 4 || mask == 8 || mask == 3 || mask == 12 || !legal))
                continue;
            prog_all(32'hA5A5_5A5A ^ 32'(m));
            wreg(4'd3, {12'b0, mask});
            run_op(4'b0100, c);
            if (legal) begin
                chk("R7 erase cycles", 32'(c), 32'(ERASE + 1));
                for (int i = 0; i < NW; i++) if (mask[i / 4]) em[i] = '1;
            end else begin
                chk("R7 bad mask no start", 32'(c), 32'h0);
                rreg(4'd8, s); chk("R7 bad mask err", 32'(s), 32'h1);
                wreg(4'd8, 16'h0001);
            end
            check_all("R7 array");
        end

        // R6: double-word program at every even address
        for (int i = 0; i < NW; i++) em[i] = em[i];
        prog_all(32'hFFFF_FFFF);
        for (int k = 0; k < NW / 2; k++) begin
            logic [31:0] x, y;
            x = 32'hF0FF_FF0F ^ 32'(k);
            y = 32'hFF0F_0FFF ^ (32'(k) << 12);
            load(16'(2 * k), x, y);
            run_op(4'b0010, c);
            chk("R6 busy cycles", 32'(c), 32'(PROG + 1));
            em[2*k] = em[2*k] & x;
            em[2*k+1] = em[2*k+1] & y;
        end
        check_all("R6 array");
        load(16'd3, 32'h0, 32'h0);
        run_op(4'b0010, c);
        chk("R6 odd no start", 32'(c), 32'h0);
        rreg(4'd8, s); chk("R6 odd err", 32'(s), 32'h1);
        rarr(16'd3, d, inv); chk("R6 odd unchanged", d, em[3]);
        wreg(4'd8, 16'h0001);
        rreg(4'd8, s); chk("R12 clear", 32'(s), 32'h0);

        // R2 R3 R4 R10: observe during an erase of sector 2 (bank 1)
        prog_all(32'h1234_5678);
        wreg(4'd3, 16'h0004);
        wreg(4'd2, 16'h0008);
        wreg(4'd1, 16'h0004);
        wreg(4'd0, 16'h0001);
        rreg(4'd0, s); chk("R2 stat after start", 32'(s), 32'h000A);
        rarr(16'd9, d, inv);
        chk("R3 busy bank invalid", 32'(inv), 32'h1);
        chk("R3 busy bank data", d, 32'h0);
        rarr(16'd1, d, inv);
        chk("R3 other bank valid", {31'b0, inv}, 32'h0);
        chk("R3 other bank data", d, em[1]);
        rarr(16'h0200, d, inv); chk("R3 unmapped", 32'(inv), 32'h1);
        rreg(4'd2, s); chk("R4 locked read", 32'(s), 32'(INV));
        wreg(4'd2, 16'h0005);
        wreg(4'd0, 16'h0001);
        for (int g = 0; g < 100; g++) begin
            rreg(4'd0, s);
            if (!s[1]) break;
        end
        for (int i = 8; i < 12; i++) em[i] = '1;
        rreg(4'd0, s); chk("R10 stat clear", 32'(s), 32'h0);
        rreg(4'd0, s); chk("R4 no second start", 32'(s), 32'h0);
        rreg(4'd1, s); chk("R10 opsel clear", 32'(s), 32'h0);
        rreg(4'd2, s); chk("R4 write ignored", 32'(s), 32'h0008);
        check_all("R10 array");

        // R11: suspend and resume an erase of sector 3
        prog_all(32'h0F0F_F0F0);
        wreg(4'd3, 16'h0008);
        wreg(4'd1, 16'h0004);
        wreg(4'd0, 16'h0001);
        rreg(4'd0, s); chk("R11 running", 32'(s), 32'h000A);
        wreg(4'd0, 16'h0010);
        rreg(4'd0, s); chk("R11 suspended stat", 32'(s), 32'h0012);
        rarr(16'd13, d, inv);
        chk("R11 bank readable", {31'b0, inv}, 32'h0);
        chk("R11 old data", d, em[13]);
        repeat (3 * ERASE) @(negedge clk);
        rreg(4'd0, s); chk("R11 still suspended", 32'(s), 32'h0012);
        rreg(4'd1, s); chk("R11 still locked", 32'(s), 32'(INV));
        wreg(4'd0, 16'h0020);
        rreg(4'd0, s); chk("R11 resumed", 32'(s), 32'h000A);
        c = 0;
        for (int g = 0; g < 100; g++) begin
            rreg(4'd0, s);
            if (!s[1]) break;
            c++;
        end
        chk("R11 remaining bounded", 32'(c <= ERASE + 1), 32'h1);
        for (int i = 12; i < 16; i++) em[i] = '1;
        check_all("R11 array");

        // R8: protection writes inside and outside the window
        for (int k = 0; k < 2; k++) begin
            d = 32'hFFFF_0F0F ^ (32'(k + 1) << 8);
            load(PBASE + 16'(k), d, 32'h0);
            run_op(4'b1000, c);
            chk("R8 prot cycles", 32'(c), 32'(PROG + 1));
            ep[k] = ep[k] & d;
        end
        for (int b = 0; b < 4; b++) begin
            logic [15:0] a;
            a = (b == 0) ? PBASE - 16'd1 : (b == 1) ? PBASE + 16'd2 : (b == 2) ? 16'd0 : 16'hFFFF;
            load(a, 32'h0, 32'h0);
            run_op(4'b1000, c);
            chk("R8 outside no start", 32'(c), 32'h0);
            rreg(4'd8, s); chk("R8 outside err", 32'(s), 32'h1);
            wreg(4'd8, 16'h0001);
        end
        for (int k = 0; k < 2; k++) begin
            rarr(PBASE + 16'(k), d, inv);
            chk("R8 prot readback", d, ep[k]);
        end

        // R9: every select code that is not one-hot, and program outside the array
        for (int o = 0; o < 16; o++) begin
            if ($countones(4'(o)) == 1) continue;
            load(16'd0, 32'h0, 32'h0);
            run_op(4'(o), c);
            chk("R9 bad select no start", 32'(c), 32'h0);
            rreg(4'd8, s); chk("R9 bad select err", 32'(s), 32'h1);
            wreg(4'd8, 16'h0001);
        end
        load(16'(NW), 32'h0, 32'h0);
        run_op(4'b0001, c);
        chk("R9 outside array", 32'(c), 32'h0);
        check_all("R9 array unchanged");

        // R12: clear attempted while locked is ignored
        load(16'd4, 32'hFFFF_FFFF, 32'h0);
        wreg(4'd1, 16'h0001);
        wreg(4'd0, 16'h0001);
        wreg(4'd8, 16'h0001);
        for (int g = 0; g < 100; g++) begin
            rreg(4'd0, s);
            if (!s[1]) break;
        end
        rreg(4'd8, s); chk("R12 locked clear ignored", 32'(s), 32'h1);
        wreg(4'd8, 16'h0001);
        rreg(4'd8, s); chk("R12 unlocked clear", 32'(s), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule